// File: doc/BRIEF.md
# ROM Search Triplet Unit

This block carries out a single decision step of the single-wire ROM search. When it is started, it asks a bit-slot engine for two read slots. The first read slot returns the id bit and the second returns its complement. The unit then picks a branch direction and asks the engine for one write slot that carries that direction. It reports the result as a 3-bit status word along with a one-cycle done strobe.

The unit talks to the slot engine over two valid/ready channels: one carries requests and the other carries responses. On the request channel, once the unit raises `slot_req_valid`, it holds the kind and the bit steady until the engine accepts them with `slot_req_ready`; the engine can stall for as long as it needs. On the response channel, the unit raises `slot_rsp_ready` only while it waits for the slot it has just issued. A response offered at any other time is left alone. The preferred direction is an ordinary control input that is sampled once, at start.

The caller owns everything above one step: the 64-bit search path, discrepancy tracking, bus resets and ROM commands.

Top module: `rom_search_step`

## Requirements
- R1: After start, the unit issues a read slot (`slot_req_write`=0, `slot_req_bit`=1) for the id bit, then a second read slot for the complement bit. Each read slot is requested only after the previous response has been accepted.
- R2: When both the id bit and the complement bit read 1, the status is 3'b011 and no write slot is requested.
- R3: When both bits read 0, the write slot carries the preferred direction, and the status is {dir,0,0}.
- R4: When exactly one bit is 1, the direction is the id bit. The status is 3'b101 for id=1 and 3'b010 for id=0.
- R5: Status bit 0 is the id bit, bit 1 is the complement bit and bit 2 is the direction written. In every non-error case, bit 2 equals the bit of the write slot.
- R6: `done` is a single-cycle pulse. It is high in the cycle after the write-slot response is accepted, or in the second cycle after the complement response in the error case. `busy` is low whenever `done` is high.
- R7: `pref_dir` is sampled only in the cycle start is accepted. Changes to it during the step have no effect on the direction written.
- R8: `start` is ignored while `busy` is high, and no slot is requested while `busy` is low.
- R9: While `slot_req_valid` is high and `slot_req_ready` is low, the request and its kind and bit stay unchanged.
- R10: After reset, busy, done, slot_req_valid and slot_rsp_ready are 0 and status is 3'b000.
- R11: The status changes only in the cycle done is high, and it holds its value until the next step completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one step (accepted when idle) |
| pref_dir | input | 1 | Direction used when both read bits are 0 |
| busy | output | 1 | Step in progress |
| done | output | 1 | One-cycle completion strobe |
| status | output | 3 | {dir, complement, id}; 3'b011 signals an error |
| slot_req_valid | output | 1 | Slot request valid |
| slot_req_ready | input | 1 | Engine accepts the request |
| slot_req_write | output | 1 | 1 = write slot, 0 = read slot |
| slot_req_bit | output | 1 | Bit to write (1 for read slots) |
| slot_rsp_valid | input | 1 | Slot completed, response valid |
| slot_rsp_ready | output | 1 | Unit accepts the response |
| slot_rsp_bit | input | 1 | Sampled bus level of a read slot |

## Verification
The block has no size parameter, so the bench builds it as it stands. Every combination of id bit, complement bit and preferred direction is swept. Each combination runs with engine stall lengths of zero, one and two cycles on both channels, which reaches the request-hold rule under back-pressure. Each combination also runs with and without a burst of start pulses and a flipped preferred direction partway through the step, so the ignore and capture rules are tested on every decision path.

// File: rtl/trip_pkg.sv
package trip_pkg;
  localparam int STAT_W = 3;

  typedef struct packed {
    logic dir;
    logic cmp;
    logic id;
  } trip_stat_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ID_REQ,
    S_ID_WAIT,
    S_CMP_REQ,
    S_CMP_WAIT,
    S_DECIDE,
    S_WR_REQ,
    S_WR_WAIT
  } trip_state_t;
endpackage

// File: rtl/trip_decide.sv
module trip_decide
  import trip_pkg::*;
(
  input  logic       id_bit,
  input  logic       cmp_bit,
  input  logic       pref,
  output logic       err,
  output logic       dir,
  output trip_stat_t stat
);
  always_comb begin
    err = id_bit & cmp_bit;
    // one valid bit forces the branch, otherwise take the preference
    dir = (id_bit ^ cmp_bit) ? id_bit : pref;
    if (err) begin
      stat = '{dir: 1'b0, cmp: 1'b1, id: 1'b1};
    end else begin
      stat = '{dir: dir, cmp: cmp_bit, id: id_bit};
    end
  end
endmodule

// File: rtl/trip_seq.sv
module trip_seq
  import trip_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        pref_in,
  input  logic        err,
  input  logic        dir,
  input  trip_stat_t  stat_next,
  output logic        id_q,
  output logic        cmp_q,
  output logic        pref_q,
  output logic        busy,
  output logic        done,
  output trip_stat_t  stat_q,
  output logic        req_valid,
  input  logic        req_ready,
  output logic        req_write,
  output logic        req_bit,
  input  logic        rsp_valid,
  output logic        rsp_ready,
  input  logic        rsp_bit
);
  trip_state_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      id_q   <= 1'b0;
      cmp_q  <= 1'b0;
      pref_q <= 1'b0;
      done   <= 1'b0;
      stat_q <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          pref_q <= pref_in;
          st     <= S_ID_REQ;
        end
        S_ID_REQ:   if (req_ready) st <= S_ID_WAIT;
        S_ID_WAIT:  if (rsp_valid) begin
          id_q <= rsp_bit;
          st   <= S_CMP_REQ;
        end
        S_CMP_REQ:  if (req_ready) st <= S_CMP_WAIT;
        S_CMP_WAIT: if (rsp_valid) begin
          cmp_q <= rsp_bit;
          st    <= S_DECIDE;
        end
        S_DECIDE: begin
          if (err) begin
            stat_q <= stat_next;
            done   <= 1'b1;
            st     <= S_IDLE;
          end else begin
            st <= S_WR_REQ;
          end
        end
        S_WR_REQ:   if (req_ready) st <= S_WR_WAIT;
        S_WR_WAIT:  if (rsp_valid) begin
          stat_q <= stat_next;
          done   <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (st != S_IDLE);
    req_valid = (st == S_ID_REQ) || (st == S_CMP_REQ) || (st == S_WR_REQ);
    req_write = (st == S_WR_REQ);
    req_bit   = (st == S_WR_REQ) ? dir : 1'b1;
    rsp_ready = (st == S_ID_WAIT) || (st == S_CMP_WAIT) || (st == S_WR_WAIT);
  end
endmodule

// File: rtl/rom_search_step.sv
module rom_search_step
  import trip_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pref_dir,
  output logic              busy,
  output logic              done,
  output logic [STAT_W-1:0] status,
  output logic              slot_req_valid,
  input  logic              slot_req_ready,
  output logic              slot_req_write,
  output logic              slot_req_bit,
  input  logic              slot_rsp_valid,
  output logic              slot_rsp_ready,
  input  logic              slot_rsp_bit
);
  logic       id_q, cmp_q, pref_q, err, dir;
  trip_stat_t stat_next, stat_q;

  trip_decide u_decide (
    .id_bit (id_q),
    .cmp_bit(cmp_q),
    .pref   (pref_q),
    .err    (err),
    .dir    (dir),
    .stat   (stat_next)
  );

  trip_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .pref_in  (pref_dir),
    .err      (err),
    .dir      (dir),
    .stat_next(stat_next),
    .id_q     (id_q),
    .cmp_q    (cmp_q),
    .pref_q   (pref_q),
    .busy     (busy),
    .done     (done),
    .stat_q   (stat_q),
    .req_valid(slot_req_valid),
    .req_ready(slot_req_ready),
    .req_write(slot_req_write),
    .req_bit  (slot_req_bit),
    .rsp_valid(slot_rsp_valid),
    .rsp_ready(slot_rsp_ready),
    .rsp_bit  (slot_rsp_bit)
  );

  assign status = stat_q;
endmodule

// File: rtl/trip_chk.sv
module trip_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic [2:0] status,
  input logic       slot_req_valid,
  input logic       slot_req_ready,
  input logic       slot_req_write,
  input logic       slot_req_bit,
  input logic       slot_rsp_ready
);
  logic wr_bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_bit_q <= 1'b0;
    else if (slot_req_valid && slot_req_ready && slot_req_write) wr_bit_q <= slot_req_bit;
  end

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req_valid && !slot_req_ready |=>
      slot_req_valid && $stable(slot_req_write) && $stable(slot_req_bit));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !slot_req_valid && !slot_rsp_ready);

  p_status_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(status));

  p_err_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done && status[0] && status[1] |-> !status[2]);

  p_forced_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done && (status[0] ^ status[1]) |-> status[2] == status[0]);

  p_write_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && !(status[0] && status[1]) |-> status[2] == wr_bit_q);
endmodule

bind rom_search_step trip_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .done          (done),
  .status        (status),
  .slot_req_valid(slot_req_valid),
  .slot_req_ready(slot_req_ready),
  .slot_req_write(slot_req_write),
  .slot_req_bit  (slot_req_bit),
  .slot_rsp_ready(slot_rsp_ready)
);

// File: tb/tb_rom_search_step.sv
`timescale 1ns/1ps
module tb_rom_search_step;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, pref_dir = 1'b0;
  logic busy, done;
  logic [2:0] status;
  logic slot_req_valid, slot_req_write, slot_req_bit, slot_rsp_ready;
  logic slot_req_ready = 1'b0, slot_rsp_valid = 1'b0, slot_rsp_bit = 1'b0;
  int total = 0, bad = 0, cycles = 0;

  always #2 clk = ~clk;

  rom_search_step dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pref_dir(pref_dir),
    .busy(busy), .done(done), .status(status),
    .slot_req_valid(slot_req_valid), .slot_req_ready(slot_req_ready),
    .slot_req_write(slot_req_write), .slot_req_bit(slot_req_bit),
    .slot_rsp_valid(slot_rsp_valid), .slot_rsp_ready(slot_rsp_ready),
    .slot_rsp_bit(slot_rsp_bit)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      bad = bad + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("  test done: total=%0d bad=%0d", total + 1, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one slot on the engine side: expect a request, stall, accept, respond
  task automatic serve(input bit exp_w, input bit exp_b, input bit rbit, input int lat, input string req);
    int k;
    k = 0;
    while (!slot_req_valid && k < 20) begin
      @(negedge clk);
      k++;
    end
    chk(slot_req_valid == 1'b1, req, slot_req_valid, 1);
    chk(slot_req_write == exp_w && slot_req_bit == exp_b, req,
        {slot_req_write, slot_req_bit}, {exp_w, exp_b});
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk(slot_req_valid && slot_req_write == exp_w && slot_req_bit == exp_b,
          "R9", {slot_req_valid, slot_req_write, slot_req_bit}, {1'b1, exp_w, exp_b});
    end
    slot_req_ready = 1'b1;
    @(negedge clk);
    slot_req_ready = 1'b0;
    for (int i = 0; i < lat; i++) @(negedge clk);
    chk(slot_rsp_ready == 1'b1, req, slot_rsp_ready, 1);
    slot_rsp_valid = 1'b1;
    slot_rsp_bit   = rbit;
    @(negedge clk);
    slot_rsp_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(busy == 0 && done == 0 && slot_req_valid == 0 && slot_rsp_ready == 0, "R10",
        {busy, done, slot_req_valid, slot_rsp_ready}, 0);
    chk(status == 3'b000, "R10", status, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int idb = 0; idb < 2; idb++)
      for (int cb = 0; cb < 2; cb++)
        for (int p = 0; p < 2; p++)
          for (int lat = 0; lat < 3; lat++)
            for (int pert = 0; pert < 2; pert++) begin
              bit err, dir;
              logic [2:0] exp_stat, prev;
              int k;
              err = idb[0] & cb[0];
              dir = (idb[0] ^ cb[0]) ? idb[0] : p[0];
              exp_stat = err ? 3'b011 : {dir, cb[0], idb[0]};
              prev = status;
              start = 1'b1;
              pref_dir = p[0];
              @(negedge clk);
              start = 1'b0;
              chk(busy == 1'b1, "R8", busy, 1);
              if (pert != 0) begin
                start = 1'b1;        // R8 ignored while busy
                pref_dir = ~p[0];    // R7 not resampled
              end
              serve(1'b0, 1'b1, idb[0], lat, "R1");
              chk(status == prev, "R11", status, prev);
              start = 1'b0;
              serve(1'b0, 1'b1, cb[0], lat, "R1");
              if (err) begin
                k = 0;
                while (!done && k < 5) begin
                  chk(slot_req_valid == 1'b0, "R2", slot_req_valid, 0);
                  @(negedge clk);
                  k++;
                end
                chk(done == 1'b1, "R6", done, 1);
                chk(status == 3'b011, "R2", status, 3'b011);
              end else begin
                serve(1'b1, dir, 1'b0, lat, (pert != 0) ? "R7" : ((idb == cb) ? "R3" : "R4"));
                chk(done == 1'b1 && busy == 1'b0, "R6", {done, busy}, 2);
                chk(status == exp_stat, (idb == cb) ? "R3" : "R4", status, exp_stat);
                chk(status[2] == dir, "R5", status[2], dir);
              end
              @(negedge clk);
              chk(done == 1'b0 && busy == 1'b0 && slot_req_valid == 1'b0, "R8",
                  {done, busy, slot_req_valid}, 0);
              @(negedge clk);
              chk(status == exp_stat, "R11", status, exp_stat);
            end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule